// File: doc/BRIEF.md
# Transmit Packet Buffer with Register Push and Stream Egress

This block lets software hand whole packets to a stream consumer. Software writes 32-bit words one at a time into a push register. It then writes the packet length in bytes to a commit register. The block holds the words in a circular buffer. A packet becomes visible on the stream master port only after its commit. The packet then leaves in push order, with TLAST on its final word. The stream side is therefore store-and-forward: a consumer never sees a partial packet.

A room register reports how many more words may be pushed. Usable capacity is the buffer depth less four words. Three event lines go to an interrupt unit:
- an overrun level, raised by a push into a full buffer;
- a length-mismatch pulse, raised by a commit whose byte count disagrees with the words pushed;
- a done pulse, raised when the final word of a packet is accepted.

A keyed write to a flush register empties the buffer and clears the overrun condition.

Top module: `tx_pkt_fifo`

## Requirements
- R1: After reset, m_tvalid_o and all three event outputs are 0, and a read of address 0x0c returns DEPTH-4.
- R2: A write to address 0x10 stores one 32-bit word. The value read from 0x0c after the write is one less than before.
- R3: Pushed words that are not yet committed never assert m_tvalid_o.
- R4: A write to 0x14 with value 4*N, where N is the non-zero count of uncommitted words, commits the packet. From the next cycle the words appear in push order, and m_tlast_o is 1 only on the final word.
- R5: While m_tvalid_o is 1 and m_tready_i is 0, the outputs m_tvalid_o, m_tdata_o and m_tlast_o hold their values into the next cycle.
- R6: irq_done_o pulses for one cycle, in the cycle after the final word of a packet is accepted. Every accepted word returns one word to the room count.
- R7: A commit value that is not 4*N, or a commit when N is 0, pulses irq_mismatch_o in the next cycle. It also discards the uncommitted words, so room is restored and nothing is emitted.
- R8: A push when room is 0 drops the word and sets irq_overrun_o. The overrun level stays set until a flush, and all pushes and commits are ignored while it is set.
- R9: Writing exactly 0x000000a5 to 0x08 empties the buffer and clears irq_overrun_o, which restores room to DEPTH-4 and drops m_tvalid_o. Any other value written there has no effect.
- R10: Several committed packets queue behind one another and leave with their boundaries intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte address, used for writes and reads |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data: the room count at 0x0c, 0 at any other address |
| m_tvalid_o | output | 1 | Stream word valid |
| m_tready_i | input | 1 | Stream consumer ready |
| m_tdata_o | output | 32 | Stream word |
| m_tlast_o | output | 1 | Final word of a packet |
| irq_overrun_o | output | 1 | Overrun level, held until a flush |
| irq_mismatch_o | output | 1 | Length-mismatch pulse |
| irq_done_o | output | 1 | Packet-sent pulse |

## Verification
The bench builds the block with DEPTH = 8, which gives a capacity of four words. With this setting the bench can cover every legal packet length from one to the full capacity. Running those lengths in sequence moves the read, commit and write pointers past the buffer end several times. Each length is drained once with the consumer always ready and once with a stalling ready pattern. The same small capacity lets the bench reach the full and overrun states within a few writes.

// File: rtl/tx_pkt_pkg.sv
package tx_pkt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned REG_AW = 6;

  localparam logic [REG_AW-1:0] ADDR_FLUSH  = 6'h08;
  localparam logic [REG_AW-1:0] ADDR_ROOM   = 6'h0c;
  localparam logic [REG_AW-1:0] ADDR_PUSH   = 6'h10;
  localparam logic [REG_AW-1:0] ADDR_COMMIT = 6'h14;

  localparam logic [DATA_W-1:0] FLUSH_KEY = 32'h0000_00a5;

  typedef struct packed {
    logic push;
    logic commit;
    logic flush;
  } bus_cmd_t;
endpackage

// File: rtl/tx_pkt_decode.sv
module tx_pkt_decode
  import tx_pkt_pkg::*;
#(
  parameter int unsigned ROOM_W = 4
) (
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ROOM_W-1:0] room_i,
  output bus_cmd_t          cmd_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    cmd_o.push   = wr_i && (addr_i == ADDR_PUSH);
    cmd_o.commit = wr_i && (addr_i == ADDR_COMMIT);
    cmd_o.flush  = wr_i && (addr_i == ADDR_FLUSH) && (wdata_i == FLUSH_KEY);
  end

  assign rdata_o = (addr_i == ADDR_ROOM) ? DATA_W'(room_i) : '0;
endmodule

// File: rtl/tx_pkt_ring.sv
module tx_pkt_ring
  import tx_pkt_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_cmd_t          cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PW-1:0]     room_o,
  output logic              tvalid_o,
  input  logic              tready_i,
  output logic [DATA_W-1:0] tdata_o,
  output logic              tlast_o,
  output logic              overrun_o,
  output logic              mismatch_o,
  output logic              done_o
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH - 4);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  last_q;
  logic [PW-1:0]     wr_q, cmt_q, rd_q;
  logic              ovr_q, mism_q, done_q;

  logic [PW-1:0] occ, pend;
  logic          full, len_ok, push_ok, push_bad, commit_go, commit_bad, pop;

  assign occ        = wr_q - rd_q;
  assign pend       = wr_q - cmt_q;
  assign full       = (occ == CAP);
  // byte count must equal four times the pending words, and at least one word must be pending
  assign len_ok     = (wdata_i[1:0] == 2'b00) && (wdata_i[DATA_W-1:2] == (DATA_W-2)'(pend))
                      && (pend != '0);
  assign push_ok    = cmd_i.push && !ovr_q && !full;
  assign push_bad   = cmd_i.push && !ovr_q && full;
  assign commit_go  = cmd_i.commit && !ovr_q && len_ok;
  assign commit_bad = cmd_i.commit && !ovr_q && !len_ok;

  assign tvalid_o   = (rd_q != cmt_q);
  assign tdata_o    = mem_q[rd_q[AW-1:0]];
  assign tlast_o    = last_q[rd_q[AW-1:0]];
  assign pop        = tvalid_o && tready_i;
  assign room_o     = CAP - occ;
  assign overrun_o  = ovr_q;
  assign mismatch_o = mism_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      cmt_q  <= '0;
      rd_q   <= '0;
      last_q <= '0;
      ovr_q  <= 1'b0;
      mism_q <= 1'b0;
      done_q <= 1'b0;
    end else if (cmd_i.flush) begin
      wr_q   <= '0;
      cmt_q  <= '0;
      rd_q   <= '0;
      ovr_q  <= 1'b0;
      mism_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (push_ok) begin
        last_q[wr_q[AW-1:0]] <= 1'b0;
        wr_q <= wr_q + 1'b1;
      end
      if (commit_go) begin
        cmt_q <= wr_q;
        last_q[AW'(wr_q - 1'b1)] <= 1'b1;
      end
      if (commit_bad) wr_q <= cmt_q;
      if (pop) rd_q <= rd_q + 1'b1;
      if (push_bad) ovr_q <= 1'b1;
      mism_q <= commit_bad;
      done_q <= pop && tlast_o;
    end
  end

  a_r8_occ_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= CAP);

  a_r5_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && !tready_i && !cmd_i.flush) |=>
      (tvalid_o && $stable(tdata_o) && $stable(tlast_o)));

  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !cmd_i.flush) |=> ovr_q);

  a_r6_done_follows_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(tvalid_o && tready_i && tlast_o));

  a_r7_mismatch_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mism_q |-> (wr_q == cmt_q));

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.flush |=> (!tvalid_o && !ovr_q && room_o == CAP));
endmodule

// File: rtl/tx_pkt_fifo.sv
module tx_pkt_fifo
  import tx_pkt_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        m_tvalid_o,
  input  logic        m_tready_i,
  output logic [31:0] m_tdata_o,
  output logic        m_tlast_o,
  output logic        irq_overrun_o,
  output logic        irq_mismatch_o,
  output logic        irq_done_o
);
  bus_cmd_t      cmd;
  logic [PW-1:0] room;

  tx_pkt_decode #(.ROOM_W(PW)) u_decode (
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .room_i  (room),
    .cmd_o   (cmd),
    .rdata_o (reg_rdata_o)
  );

  tx_pkt_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .wdata_i    (reg_wdata_i),
    .room_o     (room),
    .tvalid_o   (m_tvalid_o),
    .tready_i   (m_tready_i),
    .tdata_o    (m_tdata_o),
    .tlast_o    (m_tlast_o),
    .overrun_o  (irq_overrun_o),
    .mismatch_o (irq_mismatch_o),
    .done_o     (irq_done_o)
  );
endmodule

// File: tb/tx_pkt_fifo_tb_top.sv
module tx_pkt_fifo_tb_top;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned CAP   = DEPTH - 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tvalid, tready = 1'b0, tlast;
  logic [31:0] tdata;
  logic        ovr, mism, done;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tx_pkt_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .m_tvalid_o(tvalid), .m_tready_i(tready), .m_tdata_o(tdata), .m_tlast_o(tlast),
    .irq_overrun_o(ovr), .irq_mismatch_o(mism), .irq_done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 6'h0c;
    #1;
  endtask

  function automatic logic [31:0] room_now();
    return rdata;
  endfunction

  // drain len words starting at base; mode 0: always ready, 1: stalling pattern
  task automatic drain(input int len, input logic [31:0] base, input int mode, input string req);
    int idx = 0;
    int cyc = 0;
    logic [31:0] held_d;
    logic held_l;
    logic stalled = 1'b0;
    while (idx < len && cyc < 200) begin
      @(negedge clk);
      tready = (mode == 0) ? 1'b1 : ((cyc % 3) == 2);
      #1;
      if (stalled) begin
        check("R5 tvalid held", {31'b0, tvalid}, 32'd1);
        check("R5 tdata held", tdata, held_d);
        check("R5 tlast held", {31'b0, tlast}, {31'b0, held_l});
      end
      stalled = 1'b0;
      if (tvalid && tready) begin
        check({req, " data order"}, tdata, base + idx);
        check({req, " tlast position"}, {31'b0, tlast}, {31'b0, (idx == len - 1)});
        idx++;
      end else if (tvalid) begin
        stalled = 1'b1; held_d = tdata; held_l = tlast;
      end
      cyc++;
    end
    @(negedge clk);
    tready = 1'b0;
    #1;
    check("R6 done pulse", {31'b0, done}, 32'd1);
    check("R6 room restored", rdata, CAP);
    @(negedge clk); #1;
    check("R6 done one cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    addr = 6'h0c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 tvalid", {31'b0, tvalid}, 32'd0);
    check("R1 room", rdata, CAP);
    check("R1 events", {29'b0, ovr, mism, done}, 32'd0);

    // every length, both ready patterns; pointers wrap
    for (int mode = 0; mode < 2; mode++) begin
      for (int len = 1; len <= CAP; len++) begin
        logic [31:0] base = 32'h1000 * (len + 4 * mode) + 32'h11;
        for (int i = 0; i < len; i++) begin
          reg_write(6'h10, base + i);
          check("R2 room after push", rdata, CAP - i - 1);
          check("R3 no valid before commit", {31'b0, tvalid}, 32'd0);
        end
        reg_write(6'h14, 4 * len);
        check("R4 valid after commit", {31'b0, tvalid}, 32'd1);
        drain(len, base, mode, "R4");
      end
    end

    // mismatch: wrong byte count
    reg_write(6'h10, 32'hA);
    reg_write(6'h10, 32'hB);
    reg_write(6'h14, 32'd12);
    check("R7 mismatch pulse", {31'b0, mism}, 32'd1);
    check("R7 room restored", rdata, CAP);
    check("R7 nothing emitted", {31'b0, tvalid}, 32'd0);
    @(negedge clk); #1;
    check("R7 pulse one cycle", {31'b0, mism}, 32'd0);
    // mismatch: non-multiple of four
    reg_write(6'h10, 32'hC);
    reg_write(6'h14, 32'd5);
    check("R7 unaligned mismatch", {31'b0, mism}, 32'd1);
    check("R7 unaligned dropped", rdata, CAP);
    // mismatch: commit with nothing pending
    reg_write(6'h14, 32'd4);
    check("R7 empty commit mismatch", {31'b0, mism}, 32'd1);
    check("R7 empty commit no valid", {31'b0, tvalid}, 32'd0);

    // overrun
    for (int i = 0; i < CAP; i++) reg_write(6'h10, 32'h50 + i);
    check("R8 full room", rdata, 32'd0);
    check("R8 no overrun yet", {31'b0, ovr}, 32'd0);
    reg_write(6'h10, 32'hDEAD);
    check("R8 overrun set", {31'b0, ovr}, 32'd1);
    reg_write(6'h14, 4 * CAP);
    check("R8 commit ignored", {31'b0, tvalid}, 32'd0);
    check("R8 overrun held", {31'b0, ovr}, 32'd1);
    reg_write(6'h08, 32'h5a);
    check("R9 wrong key no effect overrun", {31'b0, ovr}, 32'd1);
    check("R9 wrong key no effect room", rdata, 32'd0);
    reg_write(6'h08, 32'ha5);
    check("R9 flush clears overrun", {31'b0, ovr}, 32'd0);
    check("R9 flush room", rdata, CAP);
    check("R9 flush no valid", {31'b0, tvalid}, 32'd0);

    // flush of a committed packet
    for (int i = 0; i < 3; i++) reg_write(6'h10, 32'h70 + i);
    reg_write(6'h14, 32'd12);
    check("R9 committed visible", {31'b0, tvalid}, 32'd1);
    reg_write(6'h08, 32'ha5);
    check("R9 committed flushed", {31'b0, tvalid}, 32'd0);
    check("R9 room after flush", rdata, CAP);

    // two packets queued: 1 word then 2 words
    reg_write(6'h10, 32'h200);
    reg_write(6'h14, 32'd4);
    reg_write(6'h10, 32'h201);
    reg_write(6'h10, 32'h202);
    reg_write(6'h14, 32'd8);
    check("R10 room with two queued", rdata, CAP - 3);
    begin
      int idx = 0;
      int dones = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        tready = 1'b1;
        #1;
        if (done) dones++;
        if (tvalid) begin
          check("R10 data order", tdata, 32'h200 + idx);
          check("R10 boundary", {31'b0, tlast}, {31'b0, (idx == 0 || idx == 2)});
          idx++;
        end
      end
      tready = 1'b0;
      check("R10 word count", idx, 32'd3);
      check("R10 done count", dones, 32'd2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule